// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Generator

This block drives a bank of hobby-servo control lines from one clock. A single frame counter runs over a programmable number of clock ticks, and every channel compares that shared count against its own on-time to form a pulse. Each pulse starts at the first tick of the frame. Because all channels share the counter, their rising edges line up. All timing values are whole clock ticks. With a 50 MHz clock one tick is 20 ns, so the usual 20 ms frame is 1,000,000 ticks.

A host programs the block through a simple register port. The port has an address, write data, a write strobe and combinational read data. There is one frame-length register, one on-time register per channel and a configuration word. The configuration word holds a per-channel enable bit and a global enable bit. A line pulses only when both its own bit and the global bit are set. The configuration word reads back, so the host can change one channel's enable with a read-modify-write.

New frame lengths and on-times are held in shadow registers and loaded only at a frame boundary. A pulse in progress is therefore never cut short or stretched. Enable changes act on the next clock.

Top module: `servo_pwm_bank`

## Requirements
- R1: An active-low reset clears the configuration word, so every output is low. It also sets the frame length register to RESET_PERIOD ticks (default 1,000,000).
- R2: The frame length register is at address 0x00, the configuration word at 0x01, and the on-time of channel n at 0x10+n. Reads return the last value written, and every other address reads as zero.
- R3: An enabled channel with 0 < on-time < frame length is high for exactly on-time ticks from the frame start and low for the rest. The frame repeats every frame-length ticks, and a frame length of 0 behaves as 1.
- R4: An enabled channel whose on-time is at least the effective frame length stays high continuously.
- R5: An enabled channel whose on-time is zero stays low continuously.
- R6: Bit n of the configuration word enables channel n, and bit 31 is the global enable. An output can be high only while both bits are set, and enable writes act from the next clock.
- R7: An on-time written in mid-frame leaves the current pulse unchanged and applies from the next frame.
- R8: A frame length written in mid-frame leaves the current frame length unchanged and applies from the next frame.
- R9: All enabled channels with a non-zero on-time rise on the same clock at the frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, one write per clock it is high |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| servo_out | output | NUM_CH | One pulse line per channel, bit n is channel n |

## Verification
The bench builds the block with four channels and a RESET_PERIOD of 50 ticks. With these values the frame that follows reset ends quickly, and programmed frames of a few dozen ticks can be measured edge to edge. The small frames make it practical to reach the edge cases: a frame length of 0 and 1, an on-time equal to or above the frame, an on-time of zero, and writes that land in mid-frame. The frame-boundary shadowing and the cross-channel alignment are then observed over several whole frames.

// File: rtl/servo_pkg.sv
package servo_pkg;
  // Common arithmetic width; callers zero-extend their tick values into it.
  localparam int CALC_W = 64;
  typedef logic [CALC_W-1:0] calc_t;

  // True on the last tick of a frame of length len (len 0 acts as 1).
  function automatic logic frame_is_last(calc_t cnt, calc_t len);
    return (cnt + calc_t'(1)) >= len;
  endfunction

  // True while the shared count lies inside the pulse window.
  function automatic logic pulse_is_on(calc_t cnt, calc_t on_time);
    return cnt < on_time;
  endfunction
endpackage

// File: rtl/servo_regs.sv
module servo_regs #(
  parameter int NUM_CH       = 8,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int TICK_W       = 32,
  parameter int RESET_PERIOD = 1_000_000,
  parameter int PERIOD_ADDR  = 0,
  parameter int CFG_ADDR     = 1,
  parameter int ONTIME_BASE  = 16,
  parameter int GLOBAL_BIT   = 31
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           we,
  output logic [DATA_W-1:0]              rdata,
  output logic [TICK_W-1:0]              period_reg,
  output logic [NUM_CH-1:0][TICK_W-1:0]  on_reg,
  output logic [NUM_CH-1:0]              ch_en,
  output logic                           glob_en
);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(PERIOD_ADDR);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(CFG_ADDR);

  logic              period_hit, cfg_hit;
  logic [NUM_CH-1:0] on_hit;
  logic [TICK_W-1:0] on_q [NUM_CH];

  assign period_hit = (addr == A_PERIOD);
  assign cfg_hit    = (addr == A_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_reg <= TICK_W'(RESET_PERIOD);
    end else if (we && period_hit) begin
      period_reg <= wdata[TICK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en   <= '0;
      glob_en <= 1'b0;
    end else if (we && cfg_hit) begin
      ch_en   <= wdata[NUM_CH-1:0];
      glob_en <= wdata[GLOBAL_BIT];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_on
    localparam logic [ADDR_W-1:0] A_ON = ADDR_W'(ONTIME_BASE + i);
    assign on_hit[i] = (addr == A_ON);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q[i] <= '0;
      end else if (we && on_hit[i]) begin
        on_q[i] <= wdata[TICK_W-1:0];
      end
    end
    assign on_reg[i] = on_q[i];
  end

  always_comb begin
    rdata = '0;
    if (period_hit) rdata[TICK_W-1:0] = period_reg;
    if (cfg_hit) begin
      rdata[NUM_CH-1:0]  = ch_en;
      rdata[GLOBAL_BIT]  = glob_en;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (on_hit[i]) rdata[TICK_W-1:0] = on_q[i];
    end
  end
endmodule

// File: rtl/servo_frame.sv
module servo_frame #(
  parameter int TICK_W       = 32,
  parameter int RESET_PERIOD = 1_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] period_reg,
  output logic [TICK_W-1:0] frame_cnt,
  output logic [TICK_W-1:0] period_act,
  output logic              frame_wrap
);
  import servo_pkg::*;

  assign frame_wrap = frame_is_last(calc_t'(frame_cnt), calc_t'(period_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt  <= '0;
      period_act <= TICK_W'(RESET_PERIOD);
    end else if (frame_wrap) begin
      frame_cnt  <= '0;
      period_act <= period_reg;
    end else begin
      frame_cnt  <= frame_cnt + TICK_W'(1);
    end
  end
endmodule

// File: rtl/servo_chan.sv
module servo_chan #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_wrap,
  input  logic [TICK_W-1:0] frame_cnt,
  input  logic [TICK_W-1:0] on_reg,
  input  logic              enable,
  output logic [TICK_W-1:0] on_act,
  output logic              pulse
);
  import servo_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_act <= '0;
    end else if (frame_wrap) begin
      on_act <= on_reg;
    end
  end

  assign pulse = enable && pulse_is_on(calc_t'(frame_cnt), calc_t'(on_act));
endmodule

// File: rtl/servo_pwm_bank.sv
module servo_pwm_bank #(
  parameter int NUM_CH       = 8,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int TICK_W       = 32,
  parameter int RESET_PERIOD = 1_000_000,
  parameter int PERIOD_ADDR  = 0,
  parameter int CFG_ADDR     = 1,
  parameter int ONTIME_BASE  = 16,
  parameter int GLOBAL_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] servo_out
);
  logic [TICK_W-1:0]             period_reg, period_act, frame_cnt;
  logic [NUM_CH-1:0][TICK_W-1:0] on_reg, on_act;
  logic [NUM_CH-1:0]             ch_en;
  logic                          glob_en, frame_wrap;

  servo_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_W(TICK_W),
    .RESET_PERIOD(RESET_PERIOD), .PERIOD_ADDR(PERIOD_ADDR), .CFG_ADDR(CFG_ADDR),
    .ONTIME_BASE(ONTIME_BASE), .GLOBAL_BIT(GLOBAL_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .rdata(reg_rdata), .period_reg(period_reg), .on_reg(on_reg),
    .ch_en(ch_en), .glob_en(glob_en)
  );

  servo_frame #(.TICK_W(TICK_W), .RESET_PERIOD(RESET_PERIOD)) u_frame (
    .clk(clk), .rst_n(rst_n), .period_reg(period_reg),
    .frame_cnt(frame_cnt), .period_act(period_act), .frame_wrap(frame_wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    servo_chan #(.TICK_W(TICK_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .frame_wrap(frame_wrap), .frame_cnt(frame_cnt),
      .on_reg(on_reg[i]), .enable(ch_en[i] && glob_en),
      .on_act(on_act[i]), .pulse(servo_out[i])
    );
  end
endmodule

// File: rtl/servo_pwm_bank_chk.sv
module servo_pwm_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int TICK_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [TICK_W-1:0]             frame_cnt,
  input logic [TICK_W-1:0]             period_act,
  input logic                          frame_wrap,
  input logic [NUM_CH-1:0][TICK_W-1:0] on_act,
  input logic                          glob_en,
  input logic [NUM_CH-1:0]             servo_out
);
  assert_cnt_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_act == '0) ? (frame_cnt == '0) : (frame_cnt < period_act));

  assert_wrap_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (frame_cnt == '0));

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (servo_out == '0));

  assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (servo_out == '0));

  assert_ontime_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(on_act));

  assert_period_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(period_act));
endmodule

bind servo_pwm_bank servo_pwm_bank_chk #(.NUM_CH(NUM_CH), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_cnt(frame_cnt), .period_act(period_act),
  .frame_wrap(frame_wrap), .on_act(on_act), .glob_en(glob_en), .servo_out(servo_out)
);

// File: tb/tb_servo_pwm_bank.sv
module tb_servo_pwm_bank;
  localparam int NCH = 4;
  localparam int RP  = 50;
  localparam int LIMIT = 500;
  localparam logic [31:0] GLOB = 32'h8000_0000;
  // {frame length, on0, on1, on2, on3}
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{20, 5, 10, 19, 0},
    '{30, 1, 29, 30, 45},
    '{12, 6, 0, 100, 3},
    '{7, 2, 3, 4, 5},
    '{0, 0, 1, 5, 0},
    '{1, 1, 0, 0, 2}
  };

  logic clk = 0, rst_n = 0, we = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] servo_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  servo_pwm_bank #(.NUM_CH(NCH), .RESET_PERIOD(RP)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_rdata(rdata), .servo_out(servo_out));

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = 8'(a); wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 8'(a);
    #1 d = rdata;
  endtask

  task automatic wait_lvl(int ch, logic lvl);
    int n = 0;
    while (servo_out[ch] !== lvl && n < LIMIT) begin @(negedge clk); n++; end
  endtask

  task automatic measure(int ch, output int hi, output int per);
    wait_lvl(ch, 1'b0); wait_lvl(ch, 1'b1);
    hi = 0;
    while (servo_out[ch] === 1'b1 && hi < LIMIT) begin hi++; @(negedge clk); end
    per = hi;
    while (servo_out[ch] === 1'b0 && per < LIMIT) begin per++; @(negedge clk); end
  endtask

  task automatic hold(string tag, int ch, logic lvl, int n);
    int miss = 0;
    repeat (n) begin @(negedge clk); if (servo_out[ch] !== lvl) miss++; end
    check(tag, miss, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, per, len;
    repeat (3) @(negedge clk);
    check("R1 outputs low in reset", int'(servo_out), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 outputs low after reset", int'(servo_out), 0);
    rd(0, d); check("R1 frame length reset value", int'(d), RP);
    rd(1, d); check("R1 config cleared", int'(d), 0);

    // R2 register map and readback
    @(negedge clk);
    wr(8'h12, 32'h0000_1234);
    rd(8'h12, d); check("R2 on-time ch2 readback", int'(d), 32'h1234);
    rd(8'h05, d); check("R2 unmapped reads zero", int'(d), 0);
    wr(1, GLOB | 32'h5);
    rd(1, d); check("R2 config readback", int'(d), int'(GLOB | 32'h5));
    wr(1, 0);

    // Vector walk: R3, R4, R5
    for (int v = 0; v < NV; v++) begin
      wr(0, 32'(VEC[v][0]));
      for (int c = 0; c < NCH; c++) wr(8'h10 + c, 32'(VEC[v][c+1]));
      wr(1, GLOB | 32'hF);
      repeat (120) @(negedge clk);
      len = (VEC[v][0] == 0) ? 1 : VEC[v][0];
      for (int c = 0; c < NCH; c++) begin
        if (VEC[v][c+1] == 0) hold($sformatf("R5 v%0d ch%0d stays low", v, c), c, 1'b0, 40);
        else if (VEC[v][c+1] >= len)
          hold($sformatf("R4 v%0d ch%0d stays high", v, c), c, 1'b1, 40);
        else begin
          measure(c, hi, per);
          check($sformatf("R3 v%0d ch%0d high ticks", v, c), hi, VEC[v][c+1]);
          check($sformatf("R3 v%0d ch%0d frame ticks", v, c), per, len);
        end
      end
    end

    // R6 gating
    wr(0, 20); wr(8'h10, 5); wr(8'h11, 5);
    wr(1, GLOB);
    repeat (60) @(negedge clk);
    hold("R6 global only keeps ch0 low", 0, 1'b0, 25);
    wr(1, 32'h3);
    hold("R6 channel bits without global keep ch0 low", 0, 1'b0, 25);
    wr(1, GLOB | 32'h1);
    measure(0, hi, per);
    check("R6 ch0 pulses when both bits set", hi, 5);
    hold("R6 ch1 low with its bit clear", 1, 1'b0, 25);
    rd(1, d); wr(1, d | 32'h2);
    rd(1, d); check("R6 read-modify-write config", int'(d), int'(GLOB | 32'h3));
    measure(1, hi, per);
    check("R6 ch1 pulses after enable", hi, 5);

    // R7 mid-frame on-time write
    wr(0, 40); wr(8'h10, 20); wr(1, GLOB | 32'h1);
    repeat (100) @(negedge clk);
    wait_lvl(0, 1'b0); wait_lvl(0, 1'b1);
    hi = 1;
    repeat (4) begin @(negedge clk); if (servo_out[0]) hi++; end
    wr(8'h10, 30);
    if (servo_out[0]) hi++;
    @(negedge clk);
    while (servo_out[0] === 1'b1 && hi < LIMIT) begin hi++; @(negedge clk); end
    check("R7 current pulse keeps old on-time", hi, 20);
    measure(0, hi, per);
    check("R7 next pulse uses new on-time", hi, 30);

    // R8 mid-frame frame length write
    wr(8'h10, 10);
    repeat (100) @(negedge clk);
    wait_lvl(0, 1'b0); wait_lvl(0, 1'b1);
    per = 0;
    wr(0, 25);
    per = 1;
    do begin @(negedge clk); per++; end while (servo_out[0] === 1'b1 && per < LIMIT);
    while (servo_out[0] === 1'b0 && per < LIMIT) begin @(negedge clk); per++; end
    check("R8 current frame keeps old length", per, 40);
    measure(0, hi, per);
    check("R8 next frame uses new length", per, 25);

    // R9 alignment
    wr(0, 30);
    for (int c = 0; c < NCH; c++) wr(8'h10 + c, 32'(3 * (c + 1)));
    wr(1, GLOB | 32'hF);
    repeat (100) @(negedge clk);
    wait_lvl(0, 1'b0); wait_lvl(0, 1'b1);
    check("R9 all channels rise together", int'(servo_out), 4'b1111);
    repeat (3) @(negedge clk);
    check("R9 shortest channel falls first", int'(servo_out), 4'b1110);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule